// File: doc/BRIEF.md
# Retire-Time Value-Checked Load Violation Table

This block holds one entry for every load that was issued speculatively, ahead of stores that are older in program order. An entry keeps the load's tag, its word address, the byte lanes it read, the value it got, and an exception flag. The flag is clear when the entry is written. Stores perform no check when they issue. Each store is checked only when it retires, and retirement is in program order. At that point the store's address, byte lanes and data are compared with every live entry at once. A store that covers an entry and writes different bytes sets the entry's flag. A store that covers the entry and writes the same bytes clears it. As a result, the store that actually supplied the value cancels any false alarms raised by earlier unrelated stores. A later store that writes back an identical value raises nothing.

When the load retires, the reorder logic queries the table by tag. The table answers combinationally whether the load is present and whether it needs a rollback that restarts fetch at that load. The entry is released at the next clock edge in both cases. A flush empties the table in one cycle. When every entry is in use, the table raises a stall on the allocation port and ignores the request.

No sequence numbers are kept. Program order is implied by the order in which stores retire. The only explicit ordering input is one bit: it tells the table whether a store retiring in the same cycle as an allocation is older than the load being allocated.

Top module: `rtv_load_checker`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, the table holds no entry: `alloc_stall` is 0 and every retire query reports `ret_found` = 0. `flush` takes priority over every other input in its cycle.
- R2: An allocation (`alloc_valid` = 1 while `alloc_stall` = 0 and `flush` = 0) records the tag, address, byte mask and data with the flag clear, unless R8 applies. From the next cycle a retire query for that tag reports `ret_found` = 1.
- R3: While all `ENTRIES` entries are live, `alloc_stall` is 1. An allocation request in that state is dropped and no live entry is overwritten.
- R4: A retiring store covers an entry when the word addresses are equal and the byte masks share at least one lane. Mask bit k selects data bits [8k+7:8k]. If any shared lane holds a different byte from the entry's data, the entry's flag is set at the next edge.
- R5: If a covering retiring store writes the same byte as the entry in every shared lane, the entry's flag is cleared at the next edge. This covers the real provider store and redundant stores of the same value.
- R6: A retiring store with a different word address, or with no shared lane, leaves the entry's flag unchanged.
- R7: A retire query (`ret_valid` = 1) reports `ret_found` = 1 when a live entry holds `ret_tag`. It reports `ret_rollback` = 1 exactly when that entry's flag is set. The flag reflects stores that retired in earlier cycles only. The entry is freed at the next edge whether or not a rollback is reported.
- R8: A store that retires in the same cycle as an allocation is compared with the new entry only when `st_older` = 1. A store that retired before the allocation cycle never affects the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drops every entry in one cycle |
| alloc_valid | input | 1 | A speculative load issues and requests an entry |
| alloc_tag | input | TAG_W | Identifier of the issuing load |
| alloc_addr | input | ADDR_W | Word address read by the load |
| alloc_be | input | DATA_W/8 | Byte lanes read by the load |
| alloc_data | input | DATA_W | Value the load obtained |
| alloc_stall | output | 1 | Table full; the allocation request is not taken |
| st_valid | input | 1 | A store retires this cycle |
| st_older | input | 1 | The retiring store is older than the load allocated in the same cycle |
| st_addr | input | ADDR_W | Word address of the retiring store |
| st_be | input | DATA_W/8 | Byte lanes written by the retiring store |
| st_data | input | DATA_W | Data written by the retiring store |
| ret_valid | input | 1 | A load reaches retirement and queries the table |
| ret_tag | input | TAG_W | Tag of the retiring load |
| ret_found | output | 1 | A live entry holds the queried tag |
| ret_rollback | output | 1 | The retiring load must be refetched |

## Verification
Any wrong flag value stays hidden until the affected load retires. It then appears as a wrong `ret_rollback`, which can be many cycles after the store that caused it. The bench therefore retires loads both right after a single store and after long random mixes of set, clear and untouched updates. A wrong valid bit appears immediately in `alloc_stall`, which the bench checks every cycle against its own table occupancy. It also shows as a wrong `ret_found` on the next query for that tag, including after a fill to capacity and after a flush.

// File: rtl/rtv_pkg.sv
package rtv_pkg;
  // width of one byte lane selected by a mask bit
  localparam int unsigned LANE_W = 8;

  // number of mask lanes needed to cover a data word
  function automatic int unsigned lanes_of(input int unsigned data_w);
    return (data_w + LANE_W - 1) / LANE_W;
  endfunction
endpackage

// File: rtl/rtv_free_pick.sv
module rtv_free_pick #(
  parameter int unsigned ENTRIES = 16
) (
  input  logic [ENTRIES-1:0] vld_vec,
  output logic [ENTRIES-1:0] grant,
  output logic               full
);
  // lowest clear bit of the occupancy vector, one-hot
  function automatic logic [ENTRIES-1:0] lowest_free(input logic [ENTRIES-1:0] v);
    return ~v & (v + ENTRIES'(1));
  endfunction

  assign grant = lowest_free(vld_vec);
  assign full  = &vld_vec;
endmodule

// File: rtl/rtv_entry.sv
module rtv_entry #(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = rtv_pkg::lanes_of(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_we,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [BE_W-1:0]   alloc_be,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic              st_valid,
  input  logic              st_older,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [BE_W-1:0]   st_be,
  input  logic [DATA_W-1:0] st_data,
  input  logic              free_req,
  output logic              vld,
  output logic [TAG_W-1:0]  tag,
  output logic              exc,
  output logic              st_hit,
  output logic              st_diff
);
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] data_q;
  logic              init_hit;
  logic              init_exc;

  // expand a lane mask to a bit mask
  function automatic logic [DATA_W-1:0] lane_bits(input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = be[i / rtv_pkg::LANE_W];
    return m;
  endfunction

  // any selected lane differs between the two words
  function automatic logic lanes_differ(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b,
                                        input logic [BE_W-1:0]   be);
    return |((a ^ b) & lane_bits(be));
  endfunction

  // same word and at least one shared lane
  function automatic logic covers(input logic [ADDR_W-1:0] a_addr,
                                  input logic [BE_W-1:0]   a_be,
                                  input logic [ADDR_W-1:0] b_addr,
                                  input logic [BE_W-1:0]   b_be);
    return (a_addr == b_addr) && (|(a_be & b_be));
  endfunction

  assign st_hit   = st_valid && vld && covers(addr_q, be_q, st_addr, st_be);
  assign st_diff  = lanes_differ(data_q, st_data, be_q & st_be);
  assign init_hit = st_valid && st_older && covers(alloc_addr, alloc_be, st_addr, st_be);
  assign init_exc = init_hit && lanes_differ(alloc_data, st_data, alloc_be & st_be);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      exc    <= 1'b0;
      tag    <= '0;
      addr_q <= '0;
      be_q   <= '0;
      data_q <= '0;
    end else if (flush) begin
      vld <= 1'b0;
    end else if (alloc_we) begin
      vld    <= 1'b1;
      exc    <= init_exc;
      tag    <= alloc_tag;
      addr_q <= alloc_addr;
      be_q   <= alloc_be;
      data_q <= alloc_data;
    end else if (vld) begin
      if (free_req) vld <= 1'b0;
      if (st_hit)   exc <= st_diff;
    end
  end
endmodule

// File: rtl/rtv_tag_lookup.sv
module rtv_tag_lookup #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 6
) (
  input  logic                           ret_valid,
  input  logic [TAG_W-1:0]               ret_tag,
  input  logic [ENTRIES-1:0]             vld_vec,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  tag_vec,
  input  logic [ENTRIES-1:0]             exc_vec,
  output logic [ENTRIES-1:0]             match_vec,
  output logic                           found,
  output logic                           rollback
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = ret_valid && vld_vec[i] && (tag_vec[i] == ret_tag);
  end

  assign found    = |match_vec;
  assign rollback = |(match_vec & exc_vec);
endmodule

// File: rtl/rtv_load_checker.sv
module rtv_load_checker #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 6,
  parameter int unsigned ADDR_W  = 30,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned BE_W   = rtv_pkg::lanes_of(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_valid,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [BE_W-1:0]   alloc_be,
  input  logic [DATA_W-1:0] alloc_data,
  output logic              alloc_stall,
  input  logic              st_valid,
  input  logic              st_older,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [BE_W-1:0]   st_be,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ret_valid,
  input  logic [TAG_W-1:0]  ret_tag,
  output logic              ret_found,
  output logic              ret_rollback
);
  // named internal events, observed by the bound checker
  logic [ENTRIES-1:0]            vld_vec;
  logic [ENTRIES-1:0]            exc_vec;
  logic [ENTRIES-1:0]            st_hit_vec;
  logic [ENTRIES-1:0]            st_diff_vec;
  logic [ENTRIES-1:0]            grant_vec;
  logic [ENTRIES-1:0]            free_vec;
  logic [ENTRIES-1:0]            we_vec;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_vec;
  logic                          table_full;
  logic                          alloc_taken;

  rtv_free_pick #(.ENTRIES(ENTRIES)) u_pick (
    .vld_vec (vld_vec),
    .grant   (grant_vec),
    .full    (table_full)
  );

  assign alloc_stall = table_full;
  assign alloc_taken = alloc_valid && !table_full && !flush;
  assign we_vec      = alloc_taken ? grant_vec : '0;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    rtv_entry #(
      .TAG_W (TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
    ) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_we   (we_vec[i]),
      .alloc_tag  (alloc_tag),
      .alloc_addr (alloc_addr),
      .alloc_be   (alloc_be),
      .alloc_data (alloc_data),
      .st_valid   (st_valid),
      .st_older   (st_older),
      .st_addr    (st_addr),
      .st_be      (st_be),
      .st_data    (st_data),
      .free_req   (free_vec[i]),
      .vld        (vld_vec[i]),
      .tag        (tag_vec[i]),
      .exc        (exc_vec[i]),
      .st_hit     (st_hit_vec[i]),
      .st_diff    (st_diff_vec[i])
    );
  end

  rtv_tag_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_look (
    .ret_valid (ret_valid),
    .ret_tag   (ret_tag),
    .vld_vec   (vld_vec),
    .tag_vec   (tag_vec),
    .exc_vec   (exc_vec),
    .match_vec (free_vec),
    .found     (ret_found),
    .rollback  (ret_rollback)
  );
endmodule

// File: rtl/rtv_load_checker_chk.sv
module rtv_load_checker_chk #(
  parameter int unsigned ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               alloc_valid,
  input logic               alloc_stall,
  input logic               ret_found,
  input logic               ret_rollback,
  input logic [ENTRIES-1:0] vld_vec,
  input logic [ENTRIES-1:0] exc_vec,
  input logic [ENTRIES-1:0] st_hit_vec,
  input logic [ENTRIES-1:0] st_diff_vec
);
  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_vec == '0));

  a_r2_alloc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_stall && !flush) |=> (vld_vec != '0));

  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_stall && !flush && !ret_found) |=> (vld_vec == $past(vld_vec)));

  a_r7_rollback_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ret_rollback |-> ret_found);

  a_r7_release_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_found && !flush) |=> !alloc_stall);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_e
    // R4 and R5: a covering store leaves the flag equal to its lane comparison
    a_r4_store_update: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_vec[i] && st_hit_vec[i] && !flush) |=> (exc_vec[i] == $past(st_diff_vec[i])));

    a_r6_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_vec[i] && !st_hit_vec[i] && !flush) |=> (exc_vec[i] == $past(exc_vec[i])));
  end
endmodule

bind rtv_load_checker rtv_load_checker_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .alloc_valid  (alloc_valid),
  .alloc_stall  (alloc_stall),
  .ret_found    (ret_found),
  .ret_rollback (ret_rollback),
  .vld_vec      (vld_vec),
  .exc_vec      (exc_vec),
  .st_hit_vec   (st_hit_vec),
  .st_diff_vec  (st_diff_vec)
);

// File: tb/tb_rtv_load_checker.sv
`timescale 1ns/1ps
module tb_rtv_load_checker;
  localparam int N = 16;
  localparam int TW = 6;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int BW = 4;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n = 0, flush = 0;
  logic alloc_valid = 0; logic [TW-1:0] alloc_tag = 0; logic [AW-1:0] alloc_addr = 0;
  logic [BW-1:0] alloc_be = 0; logic [DW-1:0] alloc_data = 0; logic alloc_stall;
  logic st_valid = 0, st_older = 0; logic [AW-1:0] st_addr = 0;
  logic [BW-1:0] st_be = 0; logic [DW-1:0] st_data = 0;
  logic ret_valid = 0; logic [TW-1:0] ret_tag = 0; logic ret_found, ret_rollback;

  rtv_load_checker #(.ENTRIES(N), .TAG_W(TW), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of the table
  bit          mv[N];
  logic [TW-1:0] mt[N];
  logic [AW-1:0] ma[N];
  logic [DW-1:0] md[N];
  logic [BW-1:0] mb[N];
  bit          me[N];

  function automatic bit m_cover(logic [AW-1:0] a1, logic [BW-1:0] b1,
                                 logic [AW-1:0] a2, logic [BW-1:0] b2);
    return (a1 == a2) && ((b1 & b2) != 0);
  endfunction

  function automatic bit m_diff(logic [DW-1:0] x, logic [DW-1:0] y, logic [BW-1:0] be);
    for (int k = 0; k < BW; k++)
      if (be[k] && (x[8*k +: 8] != y[8*k +: 8])) return 1;
    return 0;
  endfunction

  function automatic bit m_full();
    for (int i = 0; i < N; i++) if (!mv[i]) return 0;
    return 1;
  endfunction

  function automatic bit m_used(logic [TW-1:0] t);
    for (int i = 0; i < N; i++) if (mv[i] && mt[i] == t) return 1;
    return 0;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // evaluate one cycle: check outputs, advance model, move to next negedge
  task automatic cyc(string req);
    bit full, fnd, rb, nv[N];
    int slot;
    #1;
    full = m_full();
    check(req, "alloc_stall", alloc_stall, full);
    if (ret_valid) begin
      fnd = 0; rb = 0;
      for (int i = 0; i < N; i++)
        if (mv[i] && mt[i] == ret_tag) begin fnd = 1; rb = me[i]; end
      check(req, "ret_found", ret_found, fnd);
      check(req, "ret_rollback", ret_rollback, rb);
    end
    if (flush) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
    end else begin
      slot = -1;
      if (alloc_valid && !full)
        for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
      for (int i = 0; i < N; i++) begin
        nv[i] = mv[i];
        if (mv[i]) begin
          if (ret_valid && mt[i] == ret_tag) nv[i] = 0;
          if (st_valid && m_cover(ma[i], mb[i], st_addr, st_be))
            me[i] = m_diff(md[i], st_data, mb[i] & st_be);
        end
      end
      for (int i = 0; i < N; i++) mv[i] = nv[i];
      if (slot >= 0) begin
        mv[slot] = 1; mt[slot] = alloc_tag; ma[slot] = alloc_addr;
        md[slot] = alloc_data; mb[slot] = alloc_be;
        me[slot] = st_valid && st_older && m_cover(alloc_addr, alloc_be, st_addr, st_be)
                   && m_diff(alloc_data, st_data, alloc_be & st_be);
      end
    end
    @(negedge clk);
    alloc_valid = 0; st_valid = 0; st_older = 0; ret_valid = 0; flush = 0;
  endtask

  task automatic put_alloc(logic [TW-1:0] t, logic [AW-1:0] a, logic [DW-1:0] d, logic [BW-1:0] b);
    alloc_valid = 1; alloc_tag = t; alloc_addr = a; alloc_data = d; alloc_be = b;
  endtask
  task automatic put_store(logic [AW-1:0] a, logic [DW-1:0] d, logic [BW-1:0] b, logic older);
    st_valid = 1; st_addr = a; st_data = d; st_be = b; st_older = older;
  endtask
  task automatic put_ret(logic [TW-1:0] t);
    ret_valid = 1; ret_tag = t;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin mv[i] = 0; me[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    cyc("R1");
    put_ret(6'd9); cyc("R1");

    // R2: allocate and retire clean
    put_alloc(6'd1, 30'd10, 32'h11223344, 4'hF); cyc("R2");
    put_ret(6'd1); cyc("R2");

    // R4 then R5: false alarm cleared by the provider-like store
    put_alloc(6'd1, 30'd10, 32'h11223344, 4'hF); cyc("R2");
    put_store(30'd10, 32'h11223399, 4'h1, 0); cyc("R4");
    put_store(30'd10, 32'h00003300, 4'h2, 0); cyc("R5");
    put_store(30'd11, 32'hDEADBEEF, 4'hF, 0); cyc("R6");
    put_ret(6'd1); cyc("R5");

    // R4 with R6: set, then non-overlapping lanes keep it set
    put_alloc(6'd2, 30'd20, 32'h0000ABCD, 4'h3); cyc("R2");
    put_store(30'd20, 32'h000000FF, 4'h1, 0); cyc("R4");
    put_store(30'd20, 32'h12340000, 4'hC, 0); cyc("R6");
    put_ret(6'd2); cyc("R4 R6");

    // R5: redundant store of same value
    put_alloc(6'd3, 30'd30, 32'h5, 4'hF); cyc("R2");
    put_store(30'd30, 32'h5, 4'hF, 0); cyc("R5");
    put_ret(6'd3); cyc("R5");

    // R8: same-cycle store older / younger, and store before allocation
    put_alloc(6'd4, 30'd40, 32'h7, 4'hF); put_store(30'd40, 32'h8, 4'hF, 1); cyc("R8");
    put_ret(6'd4); cyc("R8");
    put_alloc(6'd5, 30'd40, 32'h7, 4'hF); put_store(30'd40, 32'h8, 4'hF, 0); cyc("R8");
    put_ret(6'd5); cyc("R8");
    put_store(30'd50, 32'h1, 4'hF, 1); cyc("R8");
    put_alloc(6'd6, 30'd50, 32'h2, 4'hF); cyc("R8");
    put_ret(6'd6); cyc("R8");

    // R3: fill to capacity, extra request dropped
    flush = 1; cyc("R1");
    for (int i = 0; i < N; i++) begin
      put_alloc(TW'(10 + i), AW'(i), DW'(i), 4'hF); cyc("R3");
    end
    put_alloc(6'd40, 30'd99, 32'h99, 4'hF); cyc("R3");
    put_ret(6'd40); cyc("R3");
    for (int i = 0; i < N; i++) begin
      put_ret(TW'(10 + i)); cyc("R3");
    end

    // R1: flush drops live entries
    put_alloc(6'd7, 30'd1, 32'h1, 4'hF); cyc("R2");
    put_alloc(6'd8, 30'd2, 32'h2, 4'hF); cyc("R2");
    flush = 1; put_alloc(6'd9, 30'd3, 32'h3, 4'hF); cyc("R1");
    put_ret(6'd7); cyc("R1");
    put_ret(6'd9); cyc("R1");

    // R7: random mix
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 3 != 0) begin
        logic [TW-1:0] t;
        t = TW'($urandom);
        while (m_used(t)) t = TW'($urandom);
        put_alloc(t, AW'($urandom % 4), {4{8'($urandom % 3)}} ^ DW'($urandom % 2),
                  BW'(1 + $urandom % 15));
      end
      if ($urandom % 2 == 0)
        put_store(AW'($urandom % 4), {4{8'($urandom % 3)}} ^ DW'($urandom % 2),
                  BW'(1 + $urandom % 15), 1'($urandom));
      if ($urandom % 3 == 0) begin
        int k;
        k = int'($urandom % N);
        if (mv[k] && $urandom % 8 != 0) put_ret(mt[k]);
        else put_ret(TW'($urandom));
      end
      if ($urandom % 300 == 0) flush = 1;
      cyc("R7");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule